// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Checks

This block holds a small set of recently used page translations and turns a virtual address into a physical address within the same cycle as the request. All stored entries are compared at once. An entry covers either a normal 4 KB page or a large 4 MB page. For a large page the lower ten bits of the virtual page number do not take part in the compare and are copied straight into the physical address.

Each access is checked against the permissions stored in the matching entry. The check uses the requester's privilege (user or kernel) and whether the access is a read or a write. A request that finds no entry raises a refill request. The surrounding logic then supplies one new entry through the fill port. The slot for that entry is chosen in first-in order, or by a pseudo-random generator when a parameter selects that variant. A flush input drops every stored translation at once.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every request misses: `miss_refill`=1, `hit`=0, `prot_fault`=0, `pa`=0.
- R2: A request that matches a normal-page entry and passes the checks gives `hit`=1 and `pa` = {entry PPN, `req_va[11:0]`} in the same cycle.
- R3: A large-page entry (`fill_big`=1) ignores `req_va[21:12]` in the compare and gives `pa` = {entry PPN[19:10], `req_va[21:0]`}.
- R4: On every cycle with `req_vld`=1, exactly one of `hit`, `prot_fault`, `miss_refill` is high. A miss gives `pa`=0. With `req_vld`=0 all three are low.
- R5: A user-mode request (`req_user`=1) that matches an entry stored with `fill_kern`=1 raises `prot_fault`.
- R6: A read (`req_wr`=0) that matches an entry without read permission faults. A write (`req_wr`=1) that matches an entry without write permission faults.
- R7: A write that matches an entry whose dirty bit is clear faults, even when write permission is set.
- R8: While `prot_fault` is high, `hit` is low and `pa` is 0.
- R9: A fill whose page does not match any stored entry goes to the first-in slot. Once every slot is used, the next such fill replaces the oldest entry. A flush restarts the order at slot 0.
- R10: A fill whose page matches a stored entry rewrites that entry in place and does not advance the replacement order. No two valid entries ever match the same request.
- R11: `flush` invalidates all entries at the next clock edge and takes priority over a fill in the same cycle, so that fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Lookup request valid |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| flush | input | 1 | Invalidate all entries |
| fill_vld | input | 1 | Write one entry |
| fill_vpn | input | 20 | Virtual page number of new entry |
| fill_ppn | input | 20 | Physical page number of new entry |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_dirty | input | 1 | Page already dirty |
| fill_kern | input | 1 | Kernel-only page |
| fill_big | input | 1 | Large (4 MB) page |
| pa | output | 32 | Physical address (0 unless hit) |
| hit | output | 1 | Translation found and permitted |
| miss_refill | output | 1 | No matching entry; refill needed |
| prot_fault | output | 1 | Matching entry denies the access |

## Verification
The hardest state to reach from the ports is a fully occupied table in which an in-place rewrite has just happened. This is the only situation that shows whether a rewrite wrongly advances the replacement order. The stimulus flushes the table, fills every slot with distinct pages, rewrites one of them, and then adds one new page. Lookups then confirm that only the oldest page was displaced and that the rewritten page holds its new frame.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {REPL_FIFO = 1'b0, REPL_LFSR = 1'b1} repl_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic dirty;
    logic kern;
    logic big;
  } perm_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int SPAN_W  = 10
) (
  input  logic [VPN_W-1:0]              key,
  input  logic                          key_big,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0]            big,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [ENTRIES-1:0]            hits
);
  localparam logic [VPN_W-1:0] FULL_MASK = '1;
  localparam logic [VPN_W-1:0] BIG_MASK  = FULL_MASK << SPAN_W;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] mask;
    assign mask    = (big[i] || key_big) ? BIG_MASK : FULL_MASK;
    assign hits[i] = valid[i] && (((tags[i] ^ key) & mask) == '0);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 32,
  parameter xlat_pkg::repl_e REPL = xlat_pkg::REPL_FIFO,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  if (REPL == xlat_pkg::REPL_FIFO) begin : g_fifo
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_comb begin
      ptr_d = ptr_q;
      if (clear)        ptr_d = '0;
      else if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
    end

    assign idx = ptr_q;

    assert_fifo_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));
    assert_fifo_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr_q == '0));
  end else begin : g_lfsr
    logic [15:0] lfsr_q, lfsr_d;

    always_comb begin
      lfsr_d = lfsr_q;
      if (clear)        lfsr_d = 16'hACE1;
      else if (advance) lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= 16'hACE1;
      else        lfsr_q <= lfsr_d;
    end

    assign idx = IDX_W'(lfsr_q % 16'(ENTRIES));
  end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm (
  input  xlat_pkg::perm_t perm,
  input  logic            is_wr,
  input  logic            is_user,
  output logic            fault
);
  logic priv_bad, rd_bad, wr_bad;

  assign priv_bad = is_user && perm.kern;
  assign rd_bad   = !is_wr && !perm.rd;
  assign wr_bad   = is_wr && (!perm.wr || !perm.dirty);
  assign fault    = priv_bad || rd_bad || wr_bad;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFS_W     = 12,
  parameter int BIG_OFS_W = 22,
  parameter int ENTRIES   = 32,
  parameter xlat_pkg::repl_e REPL = xlat_pkg::REPL_FIFO,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int SPAN_W = BIG_OFS_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_wr,
  input  logic             req_user,
  input  logic             flush,
  input  logic             fill_vld,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_dirty,
  input  logic             fill_kern,
  input  logic             fill_big,
  output logic [PA_W-1:0]  pa,
  output logic             hit,
  output logic             miss_refill,
  output logic             prot_fault
);
  import xlat_pkg::*;

  // entry storage
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            wr_en;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  perm_t                         perm_q [ENTRIES];
  logic [ENTRIES-1:0]            big_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) big_vec[i] = perm_q[i].big;
  end

  // lookup side
  logic [ENTRIES-1:0] look_hits;
  logic               any_match;
  perm_t              sel_perm;
  logic [PPN_W-1:0]   sel_ppn;
  logic               sel_fault;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPAN_W(SPAN_W)) u_look_cam (
    .key(req_va[VA_W-1:OFS_W]), .key_big(1'b0), .valid(valid_q),
    .big(big_vec), .tags(tag_q), .hits(look_hits)
  );

  always_comb begin
    sel_perm = '0;
    sel_ppn  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hits[i]) begin
        sel_perm = sel_perm | perm_q[i];
        sel_ppn  = sel_ppn | ppn_q[i];
      end
    end
  end

  assign any_match = |look_hits;

  xlat_perm u_perm (
    .perm(sel_perm), .is_wr(req_wr), .is_user(req_user), .fault(sel_fault)
  );

  always_comb begin
    hit         = req_vld && any_match && !sel_fault;
    prot_fault  = req_vld && any_match && sel_fault;
    miss_refill = req_vld && !any_match;
    pa          = '0;
    if (hit) begin
      if (sel_perm.big) pa = {sel_ppn[PPN_W-1:SPAN_W], req_va[BIG_OFS_W-1:0]};
      else              pa = {sel_ppn, req_va[OFS_W-1:0]};
    end
  end

  // fill side
  logic [ENTRIES-1:0] fill_hits;
  logic               in_place;
  logic [IDX_W-1:0]   hit_idx, victim_idx, tgt_idx;
  logic               fill_go;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPAN_W(SPAN_W)) u_fill_cam (
    .key(fill_vpn), .key_big(fill_big), .valid(valid_q),
    .big(big_vec), .tags(tag_q), .hits(fill_hits)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_hits[i]) hit_idx = IDX_W'(i);
    end
  end

  assign in_place = |fill_hits;
  assign fill_go  = fill_vld && !flush;
  assign tgt_idx  = in_place ? hit_idx : victim_idx;

  xlat_victim #(.ENTRIES(ENTRIES), .REPL(REPL)) u_victim (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .advance(fill_go && !in_place), .idx(victim_idx)
  );

  // next state
  always_comb begin
    valid_d = valid_q;
    wr_en   = '0;
    if (flush) begin
      valid_d = '0;
    end else if (fill_vld) begin
      valid_d = valid_q & ~fill_hits;
      valid_d[tgt_idx] = 1'b1;
      wr_en[tgt_idx]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        tag_q[i]  <= fill_vpn;
        ppn_q[i]  <= fill_ppn;
        perm_q[i] <= '{rd: fill_rd, wr: fill_wr, dirty: fill_dirty,
                       kern: fill_kern, big: fill_big};
      end
    end
  end

  // checks
  assert_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> $onehot({hit, prot_fault, miss_refill}));
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> !(hit || prot_fault || miss_refill));
  assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[OFS_W-1:0] == req_va[OFS_W-1:0]));
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (!hit && pa == '0));
  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hits));
  assert_user_kern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_user) |-> !sel_perm.kern);
  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk, rst_n;
  logic        req_vld, req_wr, req_user;
  logic [31:0] req_va;
  logic        flush, fill_vld, fill_rd, fill_wr, fill_dirty, fill_kern, fill_big;
  logic [19:0] fill_vpn, fill_ppn;
  logic [31:0] pa;
  logic        hit, miss_refill, prot_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
    .req_wr(req_wr), .req_user(req_user), .flush(flush), .fill_vld(fill_vld),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .fill_dirty(fill_dirty), .fill_kern(fill_kern),
    .fill_big(fill_big), .pa(pa), .hit(hit), .miss_refill(miss_refill),
    .prot_fault(prot_fault)
  );

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // code: 0 miss, 1 hit, 2 fault
  // [67:36] va  [35] wr  [34] user  [33:32] code  [31:0] pa
  localparam logic [67:0] VEC [0:12] = '{
    {32'h00010ABC, 1'b0, 1'b1, 2'd1, 32'h00ABCABC},  // R2
    {32'h00010FFF, 1'b1, 1'b0, 2'd1, 32'h00ABCFFF},  // R2
    {32'h00020004, 1'b0, 1'b1, 2'd1, 32'h00123004},  // R2
    {32'h00020004, 1'b1, 1'b0, 2'd2, 32'h00000000},  // R6 write no perm
    {32'h00030008, 1'b0, 1'b0, 2'd1, 32'h00456008},  // R2
    {32'h00030008, 1'b1, 1'b0, 2'd2, 32'h00000000},  // R7 clean page
    {32'h00040010, 1'b0, 1'b1, 2'd2, 32'h00000000},  // R5 user to kernel
    {32'h00040010, 1'b1, 1'b0, 2'd1, 32'h00789010},  // R5 kernel ok
    {32'h00D12345, 1'b0, 1'b1, 2'd1, 32'h40112345},  // R3
    {32'h00FFFFFF, 1'b1, 1'b1, 2'd1, 32'h403FFFFF},  // R3
    {32'h00BFFFFF, 1'b0, 1'b0, 2'd0, 32'h00000000},  // R4 just below big page
    {32'h00050000, 1'b0, 1'b0, 2'd2, 32'h00000000},  // R6 read no perm
    {32'h01000000, 1'b0, 1'b0, 2'd0, 32'h00000000}   // R4 just above big page
  };

  task automatic look(input logic [31:0] va, input logic wr, input logic user,
                      input int code, input logic [31:0] exp_pa, input string rq);
    logic [2:0] got, exp;
    @(negedge clk);
    req_vld = 1; req_va = va; req_wr = wr; req_user = user;
    #1;
    got = {prot_fault, hit, miss_refill};
    exp = (code == 0) ? 3'b001 : (code == 1) ? 3'b010 : 3'b100;
    checks++;
    if (got !== exp || pa !== exp_pa) begin
      errors++;
      $display("FAIL %s va=%h fault/hit/miss=%b pa=%h expected %b pa=%h",
               rq, va, got, pa, exp, exp_pa);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic rd, input logic wr, input logic dty,
                      input logic kern, input logic big);
    @(negedge clk);
    req_vld = 0;
    fill_vld = 1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
    fill_dirty = dty; fill_kern = kern; fill_big = big;
    @(negedge clk);
    fill_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_vld = 0; req_va = 0; req_wr = 0; req_user = 0;
    flush = 0; fill_vld = 0; fill_vpn = 0; fill_ppn = 0; fill_rd = 0;
    fill_wr = 0; fill_dirty = 0; fill_kern = 0; fill_big = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: empty after reset
    look(32'h00010ABC, 0, 0, 0, 32'h0, "R1");
    look(32'h00000000, 1, 1, 0, 32'h0, "R1");

    // R4: idle request gives no outcome
    @(negedge clk); req_vld = 0; #1;
    checks++;
    if ({hit, miss_refill, prot_fault} !== 3'b000) begin
      errors++;
      $display("FAIL R4 idle outputs=%b expected 000", {hit, miss_refill, prot_fault});
    end

    // setup entries
    fill(20'h00010, 20'h00ABC, 1, 1, 1, 0, 0);
    fill(20'h00020, 20'h00123, 1, 0, 0, 0, 0);
    fill(20'h00030, 20'h00456, 1, 1, 0, 0, 0);
    fill(20'h00040, 20'h00789, 1, 1, 1, 1, 0);
    fill(20'h00C00, 20'h40000, 1, 1, 1, 0, 1);
    fill(20'h00050, 20'h00999, 0, 1, 1, 0, 0);

    for (int k = 0; k < 13; k++) begin
      string rq;
      rq = (k == 3 || k == 11) ? "R6" : (k == 5) ? "R7" : (k == 6 || k == 7) ? "R5" :
           (k == 8 || k == 9) ? "R3" : (k == 10 || k == 12) ? "R4" : "R2";
      look(VEC[k][67:36], VEC[k][35], VEC[k][34], int'(VEC[k][33:32]), VEC[k][31:0], rq);
    end

    // R8: fault suppresses hit and pa (checked with a write on the read-only page)
    look(32'h00020FFF, 1, 1, 2, 32'h0, "R8");

    // R9 / R10: fill order and in-place rewrite
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 0, 0);
    look(32'h00100000, 0, 0, 1, 32'h00200000, "R9");
    look(32'h0011F004, 0, 0, 1, 32'h0021F004, "R9");
    fill(20'h00105, 20'h003AA, 1, 1, 1, 0, 0);
    look(32'h00105010, 0, 0, 1, 32'h003AA010, "R10");
    fill(20'h00180, 20'h00555, 1, 1, 1, 0, 0);
    look(32'h00100000, 0, 0, 0, 32'h0, "R9 oldest evicted");
    look(32'h00101000, 0, 0, 1, 32'h00201000, "R10 order not advanced");
    look(32'h00180020, 0, 0, 1, 32'h00555020, "R9");
    look(32'h00105010, 0, 0, 1, 32'h003AA010, "R10");

    // R11: flush beats a simultaneous fill
    @(negedge clk);
    req_vld = 0; flush = 1;
    fill_vld = 1; fill_vpn = 20'h00777; fill_ppn = 20'h00888;
    fill_rd = 1; fill_wr = 1; fill_dirty = 1; fill_kern = 0; fill_big = 0;
    @(negedge clk); flush = 0; fill_vld = 0;
    look(32'h00777000, 0, 0, 0, 32'h0, "R11 fill dropped");
    look(32'h00101000, 0, 0, 0, 32'h0, "R11 entries cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule